// File: doc/BRIEF.md
# Timed Configuration-Bit Access Controller

This block sits beside a small processor's program-memory read path. It gives software a short, timed route to the nonvolatile fuse and lock bytes. Software writes a two-bit control register. When both the program-enable bit and the config-select bit are written as ones, a window opens and counts CPU cycles. A program-memory read strobe that arrives early in the window returns a configuration byte instead of flash data. A store strobe that arrives within a slightly longer span programs boot-lock bits from a data byte. The window closes by itself once it is used or once it times out.

While no window is open, or once a read arrives too late, reads pass the flash byte through unchanged. An EEPROM write in progress locks out the control register. It also blocks configuration reads and stores.

The fuse and lock bytes are modelled as registers with parameterised reset values. A programmed bit reads as 0.

Top module: `cfg_access_ctrl`

## Requirements
- R1: While no window is open, `rd_data` equals `flash_rdata` and `cfg_sel` is 0.
- R2: Control write format: `ctl_wdata[0]` is program-enable and `ctl_wdata[1]` is config-select. A write with both bits at 1 opens a window, and `ctl_bits` reads 2'b11 from the next cycle on.
- R3: A redirected read returns a byte selected by `addr`: 0x0000 gives the fuse low byte, 0x0001 gives the lock byte, and 0x0003 gives the fuse high byte. Any other address returns 0xFF.
- R4: Cycle 1 is the cycle right after the control write. A read strobe on cycles 1 to 3 is redirected, with `cfg_sel` high. A read strobe on cycle 4 or later passes flash data through.
- R5: A redirected read at any address, mapped or not, clears both control bits at the following edge.
- R6: A window with no accepted read or store stays open through cycle 4. `ctl_bits` is 0 from cycle 5.
- R7: A control write with exactly one of the two bits at 1 is ignored, and `ctl_bits` stays 0.
- R8: A store strobe on cycles 1 to 4 is accepted and closes the window. Each zero in `st_data[5:2]` clears the lock-byte bit at the same position. `addr` has no effect on the store. A store on cycle 5 or later changes nothing.
- R9: Lock-byte bits never go from 0 to 1. Bits 7, 6, 1 and 0 of the lock byte are never changed by a store.
- R10: While `ee_busy` is 1, three things are blocked. Control writes are ignored. A read inside the window returns 0xFF and leaves the window open. A store inside the window is ignored.
- R11: `lock_byte` always shows the current lock register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_wdata | input | 2 | Control write data: bit 1 is config-select, bit 0 is program-enable |
| rd_stb | input | 1 | Program-memory read instruction strobe |
| st_stb | input | 1 | Program-memory store instruction strobe |
| addr | input | 16 | Address pointer |
| st_data | input | 8 | Data byte for lock programming |
| ee_busy | input | 1 | EEPROM write in progress |
| flash_rdata | input | 8 | Flash byte for a normal read |
| rd_data | output | 8 | Read result: configuration byte or flash pass-through |
| cfg_sel | output | 1 | High when the current read is redirected to configuration data |
| ctl_bits | output | 2 | Current control bits {config-select, program-enable} |
| lock_byte | output | 8 | Current lock register |

## Verification
The embedded assertions check four properties on every cycle. The window counter never passes the store limit. An accepted read or store always closes the window. Lock bits only ever clear, and the four fixed positions never move. An EEPROM write in progress keeps the lock byte stable and keeps an idle window shut.

Only the bench scenarios can show the exact cycle edges of the two windows. They also cover the address map and the 0xFF result for unmapped or blocked reads. Finally, they show that a late strobe or a one-bit control write has no visible effect.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;
    localparam int unsigned CFG_AW = 16;
    localparam int unsigned CFG_DW = 8;

    localparam logic [CFG_AW-1:0] ADR_FUSE_LO = 16'h0000;
    localparam logic [CFG_AW-1:0] ADR_LOCK    = 16'h0001;
    localparam logic [CFG_AW-1:0] ADR_FUSE_HI = 16'h0003;

    typedef enum logic [2:0] {
        SRC_FLASH,
        SRC_FUSE_LO,
        SRC_LOCK,
        SRC_FUSE_HI,
        SRC_ONES
    } rd_src_e;
endpackage

// File: rtl/cfg_window_timer.sv
module cfg_window_timer #(
    parameter int unsigned RD_WIN = 3,
    parameter int unsigned ST_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic consume,
    output logic armed,
    output logic rd_open,
    output logic st_open
);
    localparam int unsigned CW = $clog2(ST_WIN + 1);
    localparam logic [CW-1:0] RD_LIM = CW'(RD_WIN);
    localparam logic [CW-1:0] ST_LIM = CW'(ST_WIN);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } win_t;

    win_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm_req) begin
            st_d.armed = 1'b1;
            st_d.cnt   = CW'(1);
        end else if (st_q.armed) begin
            if (consume || st_q.cnt == ST_LIM) begin
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed   = st_q.armed;
    assign rd_open = st_q.armed && (st_q.cnt <= RD_LIM);
    assign st_open = st_q.armed;

    // R6
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> (st_q.cnt >= CW'(1) && st_q.cnt <= ST_LIM));

    // R5
    consume_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && consume && !arm_req) |=> !st_q.armed);
endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store #(
    parameter logic [7:0] LOCK_RST = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] lock_q
);
    logic [7:0] lock_d;
    logic [7:0] keep_mask;

    always_comb begin
        keep_mask = 8'hFF;
        keep_mask[5:2] = wr_data[5:2];
        lock_d = lock_q;
        if (wr_en) lock_d = lock_q & keep_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= LOCK_RST;
        else        lock_q <= lock_d;
    end

    // R9
    lock_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_q & ~$past(lock_q)) == 8'h00));

    // R9
    lock_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(lock_q[7:6]) && $stable(lock_q[1:0])));
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_access_pkg::*;
(
    input  logic [CFG_AW-1:0] addr,
    input  logic              redirect,
    input  logic              blocked,
    input  logic [CFG_DW-1:0] flash_rdata,
    input  logic [CFG_DW-1:0] fuse_lo,
    input  logic [CFG_DW-1:0] fuse_hi,
    input  logic [CFG_DW-1:0] lock_val,
    output logic [CFG_DW-1:0] rd_data
);
    rd_src_e src;

    always_comb begin
        if (!redirect)               src = SRC_FLASH;
        else if (blocked)            src = SRC_ONES;
        else if (addr == ADR_FUSE_LO) src = SRC_FUSE_LO;
        else if (addr == ADR_LOCK)    src = SRC_LOCK;
        else if (addr == ADR_FUSE_HI) src = SRC_FUSE_HI;
        else                         src = SRC_ONES;
    end

    always_comb begin
        unique case (src)
            SRC_FLASH:   rd_data = flash_rdata;
            SRC_FUSE_LO: rd_data = fuse_lo;
            SRC_LOCK:    rd_data = lock_val;
            SRC_FUSE_HI: rd_data = fuse_hi;
            default:     rd_data = '1;
        endcase
    end
endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
    import cfg_access_pkg::*;
#(
    parameter logic [7:0]  FUSE_LO_VAL = 8'h62,
    parameter logic [7:0]  FUSE_HI_VAL = 8'hD9,
    parameter logic [7:0]  LOCK_RST    = 8'hFF,
    parameter int unsigned RD_WIN      = 3,
    parameter int unsigned ST_WIN      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [1:0]  ctl_wdata,
    input  logic        rd_stb,
    input  logic        st_stb,
    input  logic [15:0] addr,
    input  logic [7:0]  st_data,
    input  logic        ee_busy,
    input  logic [7:0]  flash_rdata,
    output logic [7:0]  rd_data,
    output logic        cfg_sel,
    output logic [1:0]  ctl_bits,
    output logic [7:0]  lock_byte
);
    logic arm_req, armed, rd_open, st_open;
    logic rd_redir, rd_take, st_take, consume;
    logic [7:0] lock_q;

    always_comb begin
        arm_req  = ctl_we && (ctl_wdata == 2'b11) && !ee_busy;
        rd_redir = rd_stb && rd_open;
        rd_take  = rd_redir && !ee_busy;
        st_take  = st_stb && st_open && !ee_busy;
        consume  = rd_take || st_take;
    end

    cfg_window_timer #(.RD_WIN(RD_WIN), .ST_WIN(ST_WIN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_req (arm_req),
        .consume (consume),
        .armed   (armed),
        .rd_open (rd_open),
        .st_open (st_open)
    );

    cfg_lock_store #(.LOCK_RST(LOCK_RST)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_take),
        .wr_data (st_data),
        .lock_q  (lock_q)
    );

    cfg_read_mux u_mux (
        .addr        (addr),
        .redirect    (rd_redir),
        .blocked     (ee_busy),
        .flash_rdata (flash_rdata),
        .fuse_lo     (FUSE_LO_VAL),
        .fuse_hi     (FUSE_HI_VAL),
        .lock_val    (lock_q),
        .rd_data     (rd_data)
    );

    assign cfg_sel   = rd_redir;
    assign ctl_bits  = {armed, armed};
    assign lock_byte = lock_q;

    // R1
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed) |-> (rd_data == flash_rdata && !cfg_sel));

    // R10
    busy_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_busy && !armed) |=> (ctl_bits == 2'b00));

    // R10
    busy_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_busy |=> (lock_byte == $past(lock_byte)));
endmodule

// File: tb/tb_cfg_access_ctrl.sv
module tb_cfg_access_ctrl;
    localparam logic [7:0] FLO = 8'h62;
    localparam logic [7:0] FHI = 8'hD9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_wdata = 2'b00;
    logic        rd_stb = 1'b0;
    logic        st_stb = 1'b0;
    logic [15:0] addr = 16'h0;
    logic [7:0]  st_data = 8'h0;
    logic        ee_busy = 1'b0;
    logic [7:0]  flash_rdata = 8'h0;
    logic [7:0]  rd_data;
    logic        cfg_sel;
    logic [1:0]  ctl_bits;
    logic [7:0]  lock_byte;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] q_exp[$];
    logic       q_sel[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    cfg_access_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .rd_stb(rd_stb), .st_stb(st_stb), .addr(addr), .st_data(st_data),
        .ee_busy(ee_busy), .flash_rdata(flash_rdata), .rd_data(rd_data),
        .cfg_sel(cfg_sel), .ctl_bits(ctl_bits), .lock_byte(lock_byte)
    );

    // monitor: compares every read strobe against the scoreboard
    always @(negedge clk) begin
        if (rd_stb) begin
            n_chk++;
            if (q_exp.size() == 0) begin
                n_err++;
                $display("FAIL unexpected read: actual %h expected none", rd_data);
            end else begin
                automatic logic [7:0] e = q_exp.pop_front();
                automatic logic       s = q_sel.pop_front();
                automatic string      t = q_tag.pop_front();
                if (rd_data !== e || cfg_sel !== s) begin
                    n_err++;
                    $display("FAIL %s: actual data %h sel %b, expected data %h sel %b",
                             t, rd_data, cfg_sel, e, s);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) step();
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [1:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        step();
        ctl_we = 1'b0; ctl_wdata = 2'b00;
    endtask

    task automatic do_read(input logic [15:0] a, input logic [7:0] f,
                           input logic [7:0] exp, input logic sel, input string tag);
        addr = a; flash_rdata = f; rd_stb = 1'b1;
        q_exp.push_back(exp); q_sel.push_back(sel); q_tag.push_back(tag);
        step();
        rd_stb = 1'b0;
    endtask

    task automatic do_store(input logic [15:0] a, input logic [7:0] d);
        addr = a; st_data = d; st_stb = 1'b1;
        step();
        st_stb = 1'b0;
    endtask

    initial begin
        #2000000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        step();
        // R11 reset state
        chk({6'd0, ctl_bits}, 8'h00, "R11 reset ctl_bits");
        chk(lock_byte, 8'hFF, "R11 reset lock_byte");
        // R1 pass-through while idle
        do_read(16'h0000, 8'h5A, 8'h5A, 1'b0, "R1 idle passthrough");
        do_read(16'h0001, 8'hA7, 8'hA7, 1'b0, "R1 idle passthrough 2");

        // R2 arm, R3/R5 fuse low on cycle 1
        ctl_write(2'b11);
        chk({6'd0, ctl_bits}, 8'h03, "R2 window open");
        do_read(16'h0000, 8'h11, FLO, 1'b1, "R3 fuse low cycle1");
        chk({6'd0, ctl_bits}, 8'h00, "R5 cleared after read");

        // R4 read on cycle 3 still redirected
        ctl_write(2'b11);
        idle(2);
        do_read(16'h0003, 8'h22, FHI, 1'b1, "R4 fuse high cycle3");

        // R4 read on cycle 4 passes through
        ctl_write(2'b11);
        idle(3);
        do_read(16'h0001, 8'h3C, 8'h3C, 1'b0, "R4 cycle4 passthrough");
        chk({6'd0, ctl_bits}, 8'h00, "R6 closed at cycle5");

        // R6 timeout edges
        ctl_write(2'b11);
        idle(3);
        chk({6'd0, ctl_bits}, 8'h03, "R6 open on cycle4");
        step();
        chk({6'd0, ctl_bits}, 8'h00, "R6 closed on cycle5");

        // R3/R5 unmapped address
        ctl_write(2'b11);
        do_read(16'h0002, 8'h44, 8'hFF, 1'b1, "R3 unmapped returns FF");
        chk({6'd0, ctl_bits}, 8'h00, "R5 unmapped read clears");

        // R7 single-bit writes ignored
        ctl_write(2'b01);
        chk({6'd0, ctl_bits}, 8'h00, "R7 enable only");
        do_read(16'h0000, 8'h55, 8'h55, 1'b0, "R7 no redirect");
        ctl_write(2'b10);
        chk({6'd0, ctl_bits}, 8'h00, "R7 select only");

        // R8 store on cycle 4, address ignored
        ctl_write(2'b11);
        idle(3);
        do_store(16'h1234, 8'h08);
        chk(lock_byte, 8'hCB, "R8 store cycle4 programs bits 5,4,2");
        chk({6'd0, ctl_bits}, 8'h00, "R8 store closes window");

        // R8 store on cycle 5 ignored
        ctl_write(2'b11);
        idle(4);
        do_store(16'h0001, 8'h00);
        chk(lock_byte, 8'hCB, "R8 late store ignored");

        // R9 store of ones cannot set bits; bits 1:0 fixed
        ctl_write(2'b11);
        do_store(16'h0001, 8'hFF);
        chk(lock_byte, 8'hCB, "R9 no bit set");
        ctl_write(2'b11);
        do_store(16'h0001, 8'h3C);
        chk(lock_byte, 8'hCB, "R9 fixed bits untouched");
        ctl_write(2'b11);
        do_read(16'h0001, 8'h00, 8'hCB, 1'b1, "R3 lock byte readback");

        // R10 EEPROM busy inside window
        ctl_write(2'b11);
        ee_busy = 1'b1;
        do_read(16'h0000, 8'h66, 8'hFF, 1'b1, "R10 blocked read");
        do_store(16'h0001, 8'h00);
        chk(lock_byte, 8'hCB, "R10 blocked store");
        chk({6'd0, ctl_bits}, 8'h03, "R10 window kept open");
        ee_busy = 1'b0;
        do_read(16'h0001, 8'h00, 8'hCB, 1'b1, "R10 read after busy cycle3");

        // R10 control write during busy
        ee_busy = 1'b1;
        ctl_write(2'b11);
        ee_busy = 1'b0;
        chk({6'd0, ctl_bits}, 8'h00, "R10 ctl write ignored");

        idle(2);
        n_chk++;
        if (q_exp.size() != 0) begin
            n_err++;
            $display("FAIL R1 scoreboard: actual %0d pending expected 0", q_exp.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule